// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block decides when each external bus cycle ends. A bus cycle opens with a one-cycle start strobe. From then on the block watches for three kinds of termination: an acknowledge from an external device, an error from an external device, and an acknowledge that the block raises itself. It raises its own acknowledge for chip-select accesses after a programmed number of wait states. The external acknowledge and error inputs pass through one register stage before they are used. Error outranks acknowledge.

An optional bus monitor counts down from a programmed value once the cycle has started. If nothing has ended the cycle when the count runs out, the monitor ends it with an error. It then drives the shared error line: one cycle asserted, one cycle actively negated, and then released (output enable low) so that a pullup holds the line. The internal requester sees exactly one single-cycle completion pulse per bus cycle, together with an error flag.

Top module: `bus_term_ctrl`

## Requirements
- R1: During and after reset the block is idle, with `done_o`, `done_err_o`, `err_o` and `err_oe` all low. An asynchronous reset in the middle of an error-line drive releases the line at once.
- R2: An external acknowledge (`ext_ack_i` high) given in cycle s+k, where s is the start-strobe cycle and k≥0, ends the cycle normally. `done_o` is high in cycle s+k+2 and `done_err_o` is low.
- R3: An external error and an external acknowledge given in the same cycle end the bus cycle with error (`done_err_o` high).
- R4: An external error given in the start-strobe cycle always ends the access with error, two cycles after the strobe, whatever the wait-state setting and whether the access is a chip-select access.
- R5: For a chip-select access (`cs_access` high at the strobe) with N wait states, the block acknowledges internally. `done_o` is high in cycle s+N+2 with `done_err_o` low.
- R6: An external error given in the internal-acknowledge cycle (s+N+1) or later is ignored. The access ends normally.
- R7: An external error given in cycle s+k, with 1≤k≤N, ends a chip-select access with error in cycle s+k+2.
- R8: With `mon_en` high and limit L, a cycle that no acknowledge or error ends has `done_o` and `done_err_o` high in cycle s+L+2. An acknowledge that arrives in the same cycle as the timeout wins. With `mon_en` low no timeout occurs.
- R9: On a timeout the error line is driven as follows. In the completion cycle `err_oe`=1 and `err_o`=1. In the next cycle `err_oe`=1 and `err_o`=0. In the cycle after that `err_oe`=0.
- R10: Each bus cycle produces exactly one `done_o` pulse. Start strobes while a cycle is pending, and acknowledge or error inputs after termination, have no effect.
- R11: A cycle ended by an external error does not drive the error line (`err_oe` stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-cycle bus cycle start strobe |
| cs_access | input | 1 | Chip-select access with internal acknowledge, sampled at the strobe |
| wait_states | input | WS_W | Wait states before the internal acknowledge, sampled at the strobe |
| mon_en | input | 1 | Bus monitor enable, sampled at the strobe |
| mon_limit | input | TO_W | Bus monitor timeout count, sampled at the strobe |
| ext_ack_i | input | 1 | External transfer acknowledge, active high |
| ext_err_i | input | 1 | External transfer error, active high |
| done_o | output | 1 | Single-cycle completion pulse |
| done_err_o | output | 1 | Completion was an error, valid with done_o |
| err_o | output | 1 | Value driven onto the error line |
| err_oe | output | 1 | Error line output enable |

## Verification
The hardest situation to reach from the ports is an external error that lands next to the internal acknowledge. One cycle decides whether the error ends the access or is lost. The stimulus table places a single-cycle error pulse at exact offsets from the start strobe: one cycle before, in, and one cycle after the internal-acknowledge decision. It also places one in the strobe cycle itself with zero wait states. Further vectors make the internal acknowledge and the monitor expiry coincide, and let an external error arrive ahead of a pending timeout.

// File: rtl/bterm_pkg.sv
package bterm_pkg;
  typedef enum logic {BT_IDLE, BT_PEND} bt_state_e;
  typedef enum logic [1:0] {ED_OFF, ED_ASSERT, ED_NEGATE} ed_state_e;
  typedef enum logic [1:0] {TM_NONE, TM_OK, TM_ERR, TM_TIMEOUT} term_e;
endpackage

// File: rtl/bterm_in_reg.sv
// One register stage for asynchronous-timing external inputs.
module bterm_in_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/bterm_counter.sv
// Loadable down-counter that stops at zero.
module bterm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] init,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? init : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/bterm_err_drv.sv
// Error-line driver: assert one cycle, actively negate one cycle, release.
module bterm_err_drv
  import bterm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic err_o,
  output logic err_oe
);
  ed_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (fire) st_d = ED_ASSERT;
    else begin
      case (st_q)
        ED_ASSERT: st_d = ED_NEGATE;
        ED_NEGATE: st_d = ED_OFF;
        default:   st_d = ED_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ED_OFF;
    else        st_q <= st_d;
  end

  assign err_o  = (st_q == ED_ASSERT);
  assign err_oe = (st_q != ED_OFF);

  AST_DRV_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_oe && err_o) |=> (err_oe && !err_o)); // R9
  AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_oe && !err_o) |=> (!err_oe || err_o)); // R9
  AST_DRV_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !err_o); // R9
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bterm_pkg::*;
#(
  parameter int WS_W = 4,
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            cs_access,
  input  logic [WS_W-1:0] wait_states,
  input  logic            mon_en,
  input  logic [TO_W-1:0] mon_limit,
  input  logic            ext_ack_i,
  input  logic            ext_err_i,
  output logic            done_o,
  output logic            done_err_o,
  output logic            err_o,
  output logic            err_oe
);
  localparam int IN_W = 2;

  bt_state_e   st_q, st_d;
  term_e       term;
  logic [IN_W-1:0] ext_q;
  logic        ack_q, err_q;
  logic        cs_q, mon_q, cfg_en;
  logic        start_acc, pend, int_ack;
  logic        wait_zero, to_zero;
  logic        done_d, done_err_d;

  bterm_in_reg #(.W(IN_W)) u_inreg (
    .clk(clk), .rst_n(rst_n), .d({ext_err_i, ext_ack_i}), .q(ext_q)
  );
  assign err_q = ext_q[1];
  assign ack_q = ext_q[0];

  assign pend      = (st_q == BT_PEND);
  assign start_acc = cyc_start && (st_q == BT_IDLE);
  assign cfg_en    = start_acc;

  bterm_counter #(.W(WS_W)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .run(pend),
    .init(wait_states), .zero(wait_zero)
  );

  bterm_counter #(.W(TO_W)) u_mon_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .run(pend),
    .init(mon_limit), .zero(to_zero)
  );

  assign int_ack = pend && cs_q && wait_zero;

  // Priority: error, then acknowledge, then monitor expiry.
  always_comb begin
    term = TM_NONE;
    if (pend) begin
      if (err_q)                  term = TM_ERR;
      else if (ack_q || int_ack)  term = TM_OK;
      else if (mon_q && to_zero)  term = TM_TIMEOUT;
    end
  end

  always_comb begin
    st_d = st_q;
    if (start_acc)            st_d = BT_PEND;
    else if (term != TM_NONE) st_d = BT_IDLE;
    done_d     = (term != TM_NONE);
    done_err_d = (term == TM_ERR) || (term == TM_TIMEOUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= BT_IDLE;
      done_o     <= 1'b0;
      done_err_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      done_o     <= done_d;
      done_err_o <= done_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      mon_q <= 1'b0;
    end else if (cfg_en) begin
      cs_q  <= cs_access;
      mon_q <= mon_en;
    end
  end

  bterm_err_drv u_err_drv (
    .clk(clk), .rst_n(rst_n), .fire(term == TM_TIMEOUT),
    .err_o(err_o), .err_oe(err_oe)
  );

  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && err_q) |=> (done_o && done_err_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !done_o); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cyc_start && term == TM_NONE) |=> pend); // R10
  AST_EXT_ERR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && err_q) |=> !err_o); // R11
  AST_TIMEOUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (term == TM_TIMEOUT) |=> (err_oe && err_o && done_err_o)); // R8
endmodule

// File: tb/sim_bus_term_ctrl.sv
`timescale 1ns/1ps
module sim_bus_term_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_start, cs_access, mon_en, ext_ack_i, ext_err_i;
  logic [3:0] wait_states;
  logic [7:0] mon_limit;
  logic       done_o, done_err_o, err_o, err_oe;

  always #2 clk = ~clk;

  bus_term_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cs_access(cs_access),
    .wait_states(wait_states), .mon_en(mon_en), .mon_limit(mon_limit),
    .ext_ack_i(ext_ack_i), .ext_err_i(ext_err_i), .done_o(done_o),
    .done_err_o(done_err_o), .err_o(err_o), .err_oe(err_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offsets are cycles after the start strobe; 255 = never.
  typedef struct packed {
    logic       cs;
    logic [3:0] ws;
    logic       mon;
    logic [7:0] lim;
    logic [7:0] ackd;
    logic [7:0] errd;
    logic [7:0] lat;
    logic       eerr;
    logic       edrv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 4'd0, 1'b0, 8'd0,  8'd3,   8'd255, 8'd5,  1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 4'd0, 1'b0, 8'd0,  8'd0,   8'd255, 8'd2,  1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 4'd0, 1'b0, 8'd0,  8'd2,   8'd2,   8'd4,  1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 4'd3, 1'b0, 8'd0,  8'd255, 8'd0,   8'd2,  1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 4'd0, 1'b0, 8'd0,  8'd255, 8'd0,   8'd2,  1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 4'd4, 1'b0, 8'd0,  8'd255, 8'd255, 8'd6,  1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 4'd0, 1'b0, 8'd0,  8'd255, 8'd255, 8'd2,  1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 4'd3, 1'b0, 8'd0,  8'd255, 8'd4,   8'd5,  1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 4'd0, 1'b0, 8'd0,  8'd255, 8'd1,   8'd2,  1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 4'd3, 1'b0, 8'd0,  8'd255, 8'd3,   8'd5,  1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 4'd3, 1'b0, 8'd0,  8'd255, 8'd2,   8'd4,  1'b1, 1'b0, 4'd7},  // R7
    '{1'b0, 4'd0, 1'b1, 8'd5,  8'd255, 8'd255, 8'd7,  1'b1, 1'b1, 4'd8},  // R8 R9
    '{1'b0, 4'd0, 1'b1, 8'd0,  8'd255, 8'd255, 8'd2,  1'b1, 1'b1, 4'd8},  // R8 R9
    '{1'b0, 4'd0, 1'b1, 8'd10, 8'd4,   8'd255, 8'd6,  1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 4'd2, 1'b1, 8'd2,  8'd255, 8'd255, 8'd4,  1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 4'd0, 1'b0, 8'd2,  8'd30,  8'd255, 8'd32, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 4'd0, 1'b1, 8'd3,  8'd255, 8'd2,   8'd4,  1'b1, 1'b0, 4'd11}  // R11
  };

  localparam int WIN = 40;

  task automatic run_vec(input int idx);
    vec_t v;
    int lat, pulses, derr;
    logic oe_h [WIN];
    logic eo_h [WIN];
    string rq;
    v = VEC[idx];
    rq = $sformatf("R%0d vec%0d", v.req, idx);
    lat = -1; pulses = 0; derr = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      cs_access   = v.cs;
      wait_states = v.ws;
      mon_en      = v.mon;
      mon_limit   = v.lim;
      cyc_start   = (i == 0);
      ext_ack_i   = (i == int'(v.ackd));
      ext_err_i   = (i == int'(v.errd));
      oe_h[i] = err_oe;
      eo_h[i] = err_o;
      if (done_o) begin
        pulses++;
        if (lat < 0) begin
          lat = i;
          derr = done_err_o;
        end
      end
    end
    @(negedge clk);
    cyc_start = 1'b0; ext_ack_i = 1'b0; ext_err_i = 1'b0;
    chk(lat == int'(v.lat), rq, "done latency", lat, v.lat);
    chk(derr == int'(v.eerr), rq, "error flag", derr, v.eerr);
    chk(pulses == 1, "R10", "done pulses", pulses, 1);
    if (v.edrv && lat >= 0 && lat + 2 < WIN) begin
      chk(oe_h[lat] && eo_h[lat], "R9", "assert cycle oe&err", {oe_h[lat], eo_h[lat]}, 3);
      chk(oe_h[lat+1] && !eo_h[lat+1], "R9", "negate cycle oe&err",
          {oe_h[lat+1], eo_h[lat+1]}, 2);
      chk(!oe_h[lat+2], "R9", "release cycle oe", oe_h[lat+2], 0);
    end else if (!v.edrv) begin
      int seen = 0;
      for (int i = 0; i < WIN; i++) if (oe_h[i]) seen = 1;
      chk(seen == 0, (v.req == 4'd11) ? "R11" : rq, "line not driven", seen, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int pulses, lat;
    rst_n = 1'b0;
    cyc_start = 0; cs_access = 0; mon_en = 0; ext_ack_i = 0; ext_err_i = 0;
    wait_states = '0; mon_limit = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done_o && !done_err_o, "R1", "done in reset", {done_o, done_err_o}, 0);
    chk(!err_oe && !err_o, "R1", "line in reset", {err_oe, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done_o && !err_oe, "R1", "idle after reset", {done_o, err_oe}, 0);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R10: extra strobe while pending and late acknowledge are ignored
    pulses = 0; lat = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cs_access = 0; mon_en = 0;
      cyc_start = (i == 0) || (i == 2);
      ext_ack_i = (i == 1) || (i == 3);
      ext_err_i = (i == 4);
      if (done_o) begin
        pulses++;
        if (lat < 0) lat = i;
      end
    end
    cyc_start = 0; ext_ack_i = 0; ext_err_i = 0;
    chk(pulses == 1, "R10", "pulses with stray inputs", pulses, 1);
    chk(lat == 3, "R10", "latency with stray inputs", lat, 3);

    // R1: asynchronous reset during error-line drive
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mon_en = 1; mon_limit = 8'd0; cyc_start = (i == 0);
    end
    cyc_start = 0;
    chk(err_oe && err_o, "R9", "drive before reset", {err_oe, err_o}, 3);
    rst_n = 1'b0;
    #1;
    chk(!err_oe && !done_o, "R1", "line after async reset", {err_oe, done_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!err_oe && !done_o, "R1", "idle after second reset", {err_oe, done_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule